// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction Unit

This block is the gamma stage of a display compositor. Every streamed pixel carries four components (red, green, blue, alpha) and a display-channel index. Each component of each channel is shaped by its own programmable transfer curve. The curve has sixteen linear segments, and each segment is defined by a start breakpoint, an unsigned offset and an unsigned gradient. The unit finds the segment that holds the input code, then computes offset plus gradient times the distance from that breakpoint. It rounds the result to nearest and clamps it to the largest code of the active pipeline width.

Software writes the curve points through a simple word-write port into a shadow copy. A frame-start strobe then moves the shadow copy into the working copy, so the curve never changes partway through a frame. A per-channel enable bypasses the stage. Alpha is shaped only on the one channel that has an alpha curve. A mode input selects between 12-bit and 8-bit pipelines, and the mode changes both the field layout of the point words and the clamp limit. Every result leaves the unit a fixed three cycles after its input, with a valid flag alongside.

Top module: `pwl_gamma_unit`

## Requirements
- R1: After reset every curve on every channel is the identity. In 12-bit mode an enabled pixel therefore comes out equal to its input on all four components.
- R2: While reset is asserted, `pix_valid_o` is low and the output components are zero. A pixel sampled at clock edge k has `pix_valid_o` high after edge k+2, which is three register stages. Between pixels, `pix_valid_o` is low.
- R3: The unit uses segment i, the highest index whose breakpoint is less than or equal to the input. The result is C_i + G_i × (input − X_i). It is rounded half-up to an integer code.
- R4: A curve result above the maximum code is clamped: to 4095 in 12-bit mode and to 255 in 8-bit mode.
- R5: 8-bit mode (`wide_mode_i`=0) uses only input bits [7:0]. The breakpoint is taken from first-word bits [31:24]. The offset is unsigned 8.8 in first-word bits [15:0].
- R6: 12-bit mode (`wide_mode_i`=1) takes the breakpoint from first-word bits [31:20]. The offset is unsigned 12.4 in first-word bits [15:0]. The gradient is unsigned 4.8 in second-word bits [11:0] in both modes.
- R7: The write address is a byte address. Bits [11:10] give the channel (0..2). Bits [8:7] give the component (0 red, 1 green, 2 blue, 3 alpha). Bits [6:3] give the point and bit [2] selects the second word. A write to one channel leaves the other channels unchanged.
- R8: A write lands in a shadow copy and does not change the output until the next `frame_start_i` pulse.
- R9: When `gamma_en_i[channel]` is low, all four components of that channel pass through unchanged, with the same latency.
- R10: Only channel 2 shapes alpha. On channels 0 and 1, alpha passes through unchanged, and writes to their alpha points are dropped.
- R11: A pixel tagged with channel index 3, which does not exist, passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode_i | input | 1 | 1: 12-bit pipeline, 0: 8-bit pipeline |
| gamma_en_i | input | 3 | Per-channel curve enable |
| frame_start_i | input | 1 | Moves the shadow curve points into the working copy |
| cfg_we_i | input | 1 | Point word write strobe |
| cfg_addr_i | input | 12 | Byte address of the point word |
| cfg_wdata_i | input | 32 | Point word data |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_chan_i | input | 2 | Display channel of the input pixel |
| pix_r_i | input | 12 | Red in |
| pix_g_i | input | 12 | Green in |
| pix_b_i | input | 12 | Blue in |
| pix_a_i | input | 12 | Alpha in |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | 12 | Red out |
| pix_g_o | output | 12 | Green out |
| pix_b_o | output | 12 | Blue out |
| pix_a_o | output | 12 | Alpha out |

## Verification
The assertions assume that `wide_mode_i` and `gamma_en_i` stay constant while a pixel is in flight. They also assume that in 8-bit mode a shaped pixel has zero in its upper input bits, so that the clamp bound applies. The stimulus meets both assumptions: it sends one pixel at a time, waits for that pixel to leave, and changes mode or enables only while the pipeline is empty. It also drives 8-bit codes only below 256. Breakpoints are programmed in ascending order with point 0 at zero, which is the precondition for segment selection.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;
  localparam int unsigned NUM_PTS    = 16;
  localparam int unsigned NUM_COMP   = 4;
  localparam int unsigned NUM_CHAN   = 3;
  localparam int unsigned ALPHA_CHAN = 2;
  localparam int unsigned PIX_W      = 12;  // wide pipeline code width
  localparam int unsigned NAR_W      = 8;   // narrow pipeline code width
  localparam int unsigned X_W        = 12;  // stored breakpoint field
  localparam int unsigned C_W        = 16;  // stored offset field
  localparam int unsigned G_W        = 12;  // gradient, 4.8
  localparam int unsigned FRAC       = 8;   // fraction bits of the sum
  localparam int unsigned WIDE_CF    = C_W - PIX_W;             // 4
  localparam int unsigned CA_W       = C_W + FRAC - WIDE_CF;    // 20
  localparam int unsigned SUM_W      = G_W + PIX_W + 1;         // 25
  localparam int unsigned PT_IW      = $clog2(NUM_PTS);
  localparam int unsigned CH_IW      = $clog2(NUM_CHAN + 1);

  typedef struct packed {
    logic [X_W-1:0] x;
    logic [C_W-1:0] c;
    logic [G_W-1:0] g;
  } pwl_pt_t;
endpackage

// File: rtl/pwl_coef_bank.sv
module pwl_coef_bank
  import pwl_gamma_pkg::*;
#(
  parameter int unsigned NCH = NUM_CHAN,
  parameter int unsigned ACH = ALPHA_CHAN
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic        commit_i,
  output pwl_pt_t     curve_o [NCH][NUM_COMP][NUM_PTS]
);
  pwl_pt_t shadow_q [NCH][NUM_COMP][NUM_PTS];
  pwl_pt_t shadow_d [NCH][NUM_COMP][NUM_PTS];
  pwl_pt_t active_q [NCH][NUM_COMP][NUM_PTS];

  logic [1:0]       a_ch;
  logic [1:0]       a_comp;
  logic [PT_IW-1:0] a_pt;
  logic             a_hi;
  logic             hit;

  assign a_ch   = addr_i[11:10];
  assign a_comp = addr_i[8:7];
  assign a_pt   = addr_i[6:3];
  assign a_hi   = addr_i[2];
  assign hit    = we_i && !addr_i[9] && (32'(a_ch) < NCH) &&
                  ((a_comp != 2'd3) || (32'(a_ch) == ACH));

  function automatic pwl_pt_t ident_pt(input int unsigned i);
    pwl_pt_t p;
    p.x = X_W'(i * 256);
    p.c = C_W'(i * 4096);
    p.g = G_W'(256);
    return p;
  endfunction

  always_comb begin
    shadow_d = shadow_q;
    if (hit) begin
      if (a_hi) begin
        shadow_d[a_ch][a_comp][a_pt].g = wdata_i[G_W-1:0];
      end else begin
        shadow_d[a_ch][a_comp][a_pt].x = wdata_i[31:32-X_W];
        shadow_d[a_ch][a_comp][a_pt].c = wdata_i[C_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int ch = 0; ch < int'(NCH); ch++)
        for (int k = 0; k < int'(NUM_COMP); k++)
          for (int i = 0; i < int'(NUM_PTS); i++) begin
            shadow_q[ch][k][i] <= ident_pt(i);
            active_q[ch][k][i] <= ident_pt(i);
          end
    end else begin
      if (hit)      shadow_q <= shadow_d;
      if (commit_i) active_q <= shadow_q;
    end
  end

  assign curve_o = active_q;
endmodule

// File: rtl/pwl_lane.sv
module pwl_lane
  import pwl_gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       adv_i,
  input  logic             byp_i,
  input  logic             wide_i,
  input  logic [PIX_W-1:0] pix_i,
  input  pwl_pt_t          pts_i [NUM_PTS],
  output logic [PIX_W-1:0] pix_o
);
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC - 1);

  // stage 1: segment search
  logic [PIX_W-1:0] in_n, x_sel, diff_d;
  logic [PT_IW-1:0] seg;
  logic [CA_W-1:0]  c_al_d;
  logic [CA_W-1:0]  s1_c;
  logic [G_W-1:0]   s1_g;
  logic [PIX_W-1:0] s1_d, s1_raw, s2_raw;
  logic             s1_byp, s1_wide, s2_byp, s2_wide;
  logic [SUM_W-1:0] sum_d, s2_sum;
  logic [SUM_W-FRAC:0] rnd;
  logic [PIX_W-1:0] lim, out_d, out_q;

  function automatic logic [PIX_W-1:0] bp(input logic w, input logic [X_W-1:0] xf);
    return w ? PIX_W'(xf) : PIX_W'(xf >> (X_W - NAR_W));
  endfunction

  always_comb begin
    in_n = wide_i ? pix_i : {{(PIX_W-NAR_W){1'b0}}, pix_i[NAR_W-1:0]};
    seg  = '0;
    for (int i = 0; i < int'(NUM_PTS); i++)
      if (bp(wide_i, pts_i[i].x) <= in_n) seg = PT_IW'(i);
    x_sel  = bp(wide_i, pts_i[seg].x);
    diff_d = (in_n >= x_sel) ? in_n - x_sel : '0;
    c_al_d = wide_i ? (CA_W'(pts_i[seg].c) << (FRAC - WIDE_CF)) : CA_W'(pts_i[seg].c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_c <= '0; s1_g <= '0; s1_d <= '0; s1_raw <= '0; s1_byp <= 1'b0; s1_wide <= 1'b0;
    end else if (adv_i[0]) begin
      s1_c <= c_al_d; s1_g <= pts_i[seg].g; s1_d <= diff_d;
      s1_raw <= pix_i; s1_byp <= byp_i; s1_wide <= wide_i;
    end
  end

  // stage 2: multiply-add
  assign sum_d = SUM_W'(s1_c) + SUM_W'(s1_g * s1_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_sum <= '0; s2_raw <= '0; s2_byp <= 1'b0; s2_wide <= 1'b0;
    end else if (adv_i[1]) begin
      s2_sum <= sum_d; s2_raw <= s1_raw; s2_byp <= s1_byp; s2_wide <= s1_wide;
    end
  end

  // stage 3: round and clamp
  always_comb begin
    rnd   = (SUM_W-FRAC+1)'(({1'b0, s2_sum} + {1'b0, HALF}) >> FRAC);
    lim   = s2_wide ? {PIX_W{1'b1}} : PIX_W'({NAR_W{1'b1}});
    out_d = s2_byp ? s2_raw :
            ((rnd > (SUM_W-FRAC+1)'(lim)) ? lim : rnd[PIX_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= '0;
    else if (adv_i[2])  out_q <= out_d;
  end

  assign pix_o = out_q;
endmodule

// File: rtl/pwl_gamma_unit.sv
module pwl_gamma_unit
  import pwl_gamma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode_i,
  input  logic [NUM_CHAN-1:0] gamma_en_i,
  input  logic             frame_start_i,
  input  logic             cfg_we_i,
  input  logic [11:0]      cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             pix_valid_i,
  input  logic [CH_IW-1:0] pix_chan_i,
  input  logic [PIX_W-1:0] pix_r_i,
  input  logic [PIX_W-1:0] pix_g_i,
  input  logic [PIX_W-1:0] pix_b_i,
  input  logic [PIX_W-1:0] pix_a_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_r_o,
  output logic [PIX_W-1:0] pix_g_o,
  output logic [PIX_W-1:0] pix_b_o,
  output logic [PIX_W-1:0] pix_a_o
);
  pwl_pt_t          curve [NUM_CHAN][NUM_COMP][NUM_PTS];
  pwl_pt_t          sel_pts [NUM_COMP][NUM_PTS];
  logic [2:0]       v_q, v_d;
  logic             chan_ok, byp_all;
  logic [PIX_W-1:0] comp_in  [NUM_COMP];
  logic [PIX_W-1:0] comp_out [NUM_COMP];

  pwl_coef_bank #(.NCH(NUM_CHAN), .ACH(ALPHA_CHAN)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .commit_i(frame_start_i), .curve_o(curve)
  );

  assign chan_ok = 32'(pix_chan_i) < NUM_CHAN;
  assign byp_all = !chan_ok || !gamma_en_i[chan_ok ? pix_chan_i : '0];
  assign v_d     = {v_q[1:0], pix_valid_i};

  always_comb begin
    for (int k = 0; k < int'(NUM_COMP); k++)
      sel_pts[k] = curve[chan_ok ? pix_chan_i : '0][k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  assign comp_in[0] = pix_r_i;
  assign comp_in[1] = pix_g_i;
  assign comp_in[2] = pix_b_i;
  assign comp_in[3] = pix_a_i;

  for (genvar k = 0; k < int'(NUM_COMP); k++) begin : g_lane
    logic lane_byp;
    if (k == NUM_COMP - 1) begin : g_alpha
      assign lane_byp = byp_all || (32'(pix_chan_i) != ALPHA_CHAN);
    end else begin : g_color
      assign lane_byp = byp_all;
    end
    pwl_lane u_lane (
      .clk(clk), .rst_n(rst_n), .adv_i({v_q[1], v_q[0], pix_valid_i}),
      .byp_i(lane_byp), .wide_i(wide_mode_i), .pix_i(comp_in[k]),
      .pts_i(sel_pts[k]), .pix_o(comp_out[k])
    );
  end

  assign pix_valid_o = v_q[2];
  assign pix_r_o     = comp_out[0];
  assign pix_g_o     = comp_out[1];
  assign pix_b_o     = comp_out[2];
  assign pix_a_o     = comp_out[3];
endmodule

// File: rtl/pwl_gamma_chk.sv
module pwl_gamma_chk
  import pwl_gamma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wide_mode_i,
  input logic [NUM_CHAN-1:0] gamma_en_i,
  input logic             pix_valid_i,
  input logic [CH_IW-1:0] pix_chan_i,
  input logic [PIX_W-1:0] pix_r_i,
  input logic [PIX_W-1:0] pix_g_i,
  input logic [PIX_W-1:0] pix_b_i,
  input logic [PIX_W-1:0] pix_a_i,
  input logic             pix_valid_o,
  input logic [PIX_W-1:0] pix_r_o,
  input logic [PIX_W-1:0] pix_g_o,
  input logic [PIX_W-1:0] pix_b_o,
  input logic [PIX_W-1:0] pix_a_o
);
  logic [1:0] age_q;
  logic       warm, byp_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign warm   = (age_q == 2'd3);
  assign byp_in = (32'(pix_chan_i) >= NUM_CHAN) ||
                  !gamma_en_i[(32'(pix_chan_i) < NUM_CHAN) ? pix_chan_i : '0];

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (pix_valid_o == $past(pix_valid_i, 3))); // R2

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pix_valid_i, 3) && $past(byp_in, 3)) |->
    (pix_r_o == $past(pix_r_i, 3) && pix_g_o == $past(pix_g_i, 3) &&
     pix_b_o == $past(pix_b_i, 3) && pix_a_o == $past(pix_a_i, 3))); // R9

  AST_ALPHA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pix_valid_i, 3) && (32'($past(pix_chan_i, 3)) != ALPHA_CHAN)) |->
    (pix_a_o == $past(pix_a_i, 3))); // R10

  AST_NARROW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(pix_valid_i, 3) && !$past(wide_mode_i, 3) && !$past(byp_in, 3)) |->
    (pix_r_o <= 12'd255 && pix_g_o <= 12'd255 && pix_b_o <= 12'd255)); // R4
endmodule

bind pwl_gamma_unit pwl_gamma_chk u_chk (.*);

// File: tb/pwl_gamma_unit_bench.sv
`timescale 1ns/1ps
module pwl_gamma_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode, frame_start, cfg_we, pv_i, pv_o;
  logic [2:0]  gamma_en;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [1:0]  chan;
  logic [11:0] r_i, g_i, b_i, a_i, r_o, g_o, b_o, a_o;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwl_gamma_unit u_pwl_gamma_unit (
    .clk(clk), .rst_n(rst_n), .wide_mode_i(wide_mode), .gamma_en_i(gamma_en),
    .frame_start_i(frame_start), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .pix_valid_i(pv_i), .pix_chan_i(chan),
    .pix_r_i(r_i), .pix_g_i(g_i), .pix_b_i(b_i), .pix_a_i(a_i),
    .pix_valid_o(pv_o), .pix_r_o(r_o), .pix_g_o(g_o), .pix_b_o(b_o), .pix_a_o(a_o)
  );

  typedef struct packed {
    logic        wide;
    logic [1:0]  ch;
    logic [11:0] r, g, b, a, er, eg, eb, ea;
  } vec_t;

  // Curves after the programming below. The requirements each row covers are noted.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 12'd1280, 12'd3840, 12'd1,   12'd100,  12'd1001, 12'd4000, 12'd1,   12'd100 },  // R3 R6 R10
    '{1'b1, 2'd0, 12'd1300, 12'd3841, 12'd3,   12'd100,  12'd1041, 12'd4016, 12'd2,   12'd100 },  // R3 R6
    '{1'b1, 2'd0, 12'd1279, 12'd4095, 12'd255, 12'd0,    12'd1279, 12'd4095, 12'd128, 12'd0   },  // R3 R4
    '{1'b1, 2'd0, 12'd1536, 12'd2000, 12'd256, 12'd4095, 12'd1536, 12'd2000, 12'd256, 12'd4095},  // R3
    '{1'b1, 2'd1, 12'd1300, 12'd2000, 12'd3,   12'd55,   12'd1300, 12'd2000, 12'd3,   12'd55  },  // R7 R10
    '{1'b1, 2'd2, 12'd1300, 12'd3841, 12'd3,   12'd100,  12'd1300, 12'd3841, 12'd3,   12'd16  },  // R7 R10
    '{1'b1, 2'd2, 12'd0,    12'd0,    12'd0,   12'd256,  12'd0,    12'd0,    12'd0,   12'd256 },  // R10
    '{1'b0, 2'd1, 12'd50,   12'd63,   12'd200, 12'd7,    12'd106,  12'd255,  12'd200, 12'd7   },  // R5 R4
    '{1'b0, 2'd1, 12'd47,   12'd48,   12'd255, 12'd0,    12'd47,   12'd100,  12'd255, 12'd0   },  // R5
    '{1'b0, 2'd0, 12'd90,   12'd255,  12'd3,   12'd9,    12'd83,   12'd255,  12'd2,   12'd9   }   // R5 R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  // Sends one pixel and checks the valid timing (R2) and the four components.
  task automatic px(input string tag, input logic [1:0] c,
                    input int r, input int g, input int b, input int a,
                    input int er, input int eg, input int eb, input int ea);
    @(negedge clk);
    chan = c; r_i = 12'(r); g_i = 12'(g); b_i = 12'(b); a_i = 12'(a); pv_i = 1'b1;
    @(negedge clk); pv_i = 1'b0;
    @(negedge clk); chk("R2 valid not early", int'(pv_o), 0);
    @(negedge clk); chk("R2 valid at third edge", int'(pv_o), 1);
    chk({tag, " red"}, int'(r_o), er);
    chk({tag, " green"}, int'(g_o), eg);
    chk({tag, " blue"}, int'(b_o), eb);
    chk({tag, " alpha"}, int'(a_o), ea);
    @(negedge clk); chk("R2 valid drops", int'(pv_o), 0);
  endtask

  logic done = 1'b0;
  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wide_mode = 1'b1; gamma_en = 3'b111; frame_start = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; pv_i = 1'b0; chan = '0;
    r_i = '0; g_i = '0; b_i = '0; a_i = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", int'(pv_o), 0);
    chk("R2 reset data", int'(r_o | g_o | b_o | a_o), 0);
    rst_n = 1'b1;

    // R1 identity after reset
    px("R1 ch0", 2'd0, 1234, 4095, 0, 77, 1234, 4095, 0, 77);
    px("R1 ch2", 2'd2, 17, 2048, 3999, 300, 17, 2048, 3999, 300);

    // programming (R7 address map, R6 wide and R5 narrow field layout)
    wr(12'h028, 32'h5000_3E88); wr(12'h02C, 32'h0000_0200);  // ch0 red pt5
    wr(12'h0F8, 32'hF000_FA00); wr(12'h0FC, 32'h0000_0FFF);  // ch0 green pt15
    wr(12'h100, 32'h0000_0000); wr(12'h104, 32'h0000_0080);  // ch0 blue pt0
    wr(12'h180, 32'h0000_0100); wr(12'h184, 32'h0000_0000);  // ch0 alpha, dropped (R10)
    wr(12'h980, 32'h0000_0100); wr(12'h984, 32'h0000_0000);  // ch2 alpha pt0
    wr(12'h418, 32'h3000_6400); wr(12'h41C, 32'h0000_0300);  // ch1 red pt3
    wr(12'h498, 32'h3000_6400); wr(12'h49C, 32'h0000_0FFF);  // ch1 green pt3

    // R8 no effect before the frame strobe
    px("R8 before commit", 2'd0, 1300, 3841, 3, 100, 1300, 3841, 3, 100);
    commit();
    px("R8 after commit", 2'd0, 1300, 3841, 3, 100, 1041, 4016, 2, 100);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); wide_mode = VECS[i].wide;
      px($sformatf("table row %0d R3/R4/R5/R6/R7/R10", i), VECS[i].ch,
         int'(VECS[i].r), int'(VECS[i].g), int'(VECS[i].b), int'(VECS[i].a),
         int'(VECS[i].er), int'(VECS[i].eg), int'(VECS[i].eb), int'(VECS[i].ea));
    end

    // R9 channel bypass
    @(negedge clk); wide_mode = 1'b1; gamma_en = 3'b110;
    px("R9 bypass ch0", 2'd0, 1300, 3841, 3, 100, 1300, 3841, 3, 100);
    @(negedge clk); gamma_en = 3'b011;
    px("R9 bypass ch2 alpha", 2'd2, 5, 6, 7, 100, 5, 6, 7, 100);
    @(negedge clk); gamma_en = 3'b111;
    // R11 nonexistent channel
    px("R11 ch3", 2'd3, 1300, 3841, 3, 100, 1300, 3841, 3, 100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule